// File: doc/BRIEF.md
# SDRAM Per-Bank Command Legality Checker

This block watches the command pins of a four-bank SDRAM, samples them on every rising clock edge, and judges each command against the state of the bank it names and against device-wide activity. It keeps a small state machine per bank, with timed windows for opening a row, bursting, write recovery and closing a row, plus a device tracker for refresh, mode-register loading and self refresh. It issues no commands and moves no data. It sits beside a memory controller or in a test environment and raises a flag when the command stream breaks the protocol.

Every sampled command produces, one clock later, its decoded code and a legality flag. The per-bank states and the device state are visible at all times. Every delay is a parameter counted in clocks. A command judged illegal leaves all state exactly as if a no-op had been issued.

Top module: `sdram_cmd_legality`

## Requirements
- R1: `cmdCode` shows, one clock after the sampling edge, the decoded command: NOP=0, mode load=1, refresh=2, precharge=3, activate=4, write=5, read=6, burst stop=7, deselect=8. Chip select high means deselect. Otherwise {ras,cas,we} decodes as 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 NOP.
- R2: Deselect and NOP are always legal and change no state apart from running timers.
- R3: Activate is legal only on an idle bank (bank code 0). The bank then reports opening (1) for T_RCD clocks and then open (2). While a bank is opening, only NOP, deselect and burst stop are legal on it.
- R4: Read or write is illegal on an idle, opening or closing bank. It is legal on an open, reading, writing or write-recovering bank. A read reports reading (3) for BURST_LEN clocks and then open. A write reports writing (4) for BURST_LEN clocks, then write recovery (7) for T_WR clocks, then open.
- R5: A read or write with A10 high selects auto-precharge: reading-AP (5) or writing-AP (6), then write-recovery-AP (8) after a write, then closing (9) for T_RP clocks, then idle. In these three auto-precharge states, read, write, precharge, activate and burst stop aimed at that bank are illegal.
- R6: Precharge with A10 low closes only the bank named by BA. With A10 high it closes every bank, and it is legal only if every bank permits precharge. Precharge is legal on idle, open, reading, writing and closing banks, and illegal on opening, write-recovering and auto-precharge banks. An open, reading or writing bank becomes closing and is idle after T_RP clocks.
- R7: A read or write to a bank that is mid-burst ends that burst and starts a new one with a fresh burst count. Burst stop returns a reading or writing bank to open.
- R8: A command naming bank BA is judged only against that bank's state. Other banks keep running their own timers.
- R9: Mode load and refresh are legal only when all banks and the device are idle. Mode load makes the device report mode-access (2) for T_MRD clocks. Refresh with CKE high makes it report refreshing (1) for T_RC clocks. Any command other than NOP or deselect during these windows is illegal.
- R10: When CKE is sampled low, all bank and device timers hold, and every command other than NOP or deselect is illegal. The exception is refresh with everything idle, which enters self refresh (device code 3). Self refresh ends on the first CKE-high NOP or deselect, and the device then reports refreshing for T_RC clocks.
- R11: An illegal command changes no bank or device state beyond what a NOP in the same cycle would do.
- R12: After reset, all banks and the device are idle, `illegal` is 0 and `cmdCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| cke | input | 1 | Clock enable as seen by the memory |
| cmdCode | output | 4 | Decoded command of the last sampled edge |
| illegal | output | 1 | Last sampled command broke the protocol |
| bankState | output | 16 | Four 4-bit bank state codes, bank 0 in bits 3:0 |
| devState | output | 2 | Device state: idle, refreshing, mode-access, self refresh |

## Verification
The assertions check on every cycle that the following commands are always flagged: activate to a non-idle bank, read or write to an idle bank, and mode load with any bank busy. They also check that deselect is never flagged, that CKE low freezes every bank state, and that an opening or auto-precharge bank can only move along its own path. The exact window lengths, burst restarts, all-bank precharge, self-refresh entry and exit, and the claim that illegal commands leave state untouched are shown only by the bench's scenarios. There, a behavioural model is compared against the block on every clock under directed and random command streams.

// File: rtl/sdram_legality_pkg.sv
package sdram_legality_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_MRS   = 4'd1,
    CMD_REF   = 4'd2,
    CMD_PRE   = 4'd3,
    CMD_ACT   = 4'd4,
    CMD_WR    = 4'd5,
    CMD_RD    = 4'd6,
    CMD_BST   = 4'd7,
    CMD_DESEL = 4'd8
  } cmd_e;

  typedef enum logic [3:0] {
    BK_IDLE     = 4'd0,
    BK_OPENING  = 4'd1,
    BK_OPEN     = 4'd2,
    BK_READ     = 4'd3,
    BK_WRITE    = 4'd4,
    BK_READ_AP  = 4'd5,
    BK_WRITE_AP = 4'd6,
    BK_WREC     = 4'd7,
    BK_WREC_AP  = 4'd8,
    BK_CLOSING  = 4'd9
  } bank_e;

  typedef enum logic [1:0] {
    DEV_IDLE    = 2'd0,
    DEV_REFRESH = 2'd1,
    DEV_MODE    = 2'd2,
    DEV_SELF    = 2'd3
  } dev_e;

  // strobes from control to one bank tracker
  typedef struct packed {
    logic run;
    logic act;
    logic rd;
    logic wr;
    logic ap;
    logic pre;
    logic bst;
  } bankStb_t;

  // strobes from control to the device tracker
  typedef struct packed {
    logic run;
    logic mrs;
    logic refAuto;
    logic refSelf;
    logic selfExit;
  } devStb_t;

  function automatic cmd_e decodeCmd(input logic csN, input logic rasN,
                                     input logic casN, input logic weN);
    cmd_e c;
    if (csN) c = CMD_DESEL;
    else begin
      case ({rasN, casN, weN})
        3'b000:  c = CMD_MRS;
        3'b001:  c = CMD_REF;
        3'b010:  c = CMD_PRE;
        3'b011:  c = CMD_ACT;
        3'b100:  c = CMD_WR;
        3'b101:  c = CMD_RD;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_legality_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  parameter int TW        = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  bankStb_t stb,
  output bank_e    state
);

  logic [TW-1:0] tmr;
  logic [TW-1:0] nTmr;
  bank_e         nState;
  logic          expired;
  logic          inBurst;

  assign expired = (tmr == '0);
  assign inBurst = (state == BK_READ) || (state == BK_WRITE);

  always_comb begin
    nState = state;
    nTmr   = tmr;
    if (stb.run) begin
      if (stb.act) begin
        nState = BK_OPENING;
        nTmr   = TW'(T_RCD - 1);
      end else if (stb.rd) begin
        nState = stb.ap ? BK_READ_AP : BK_READ;
        nTmr   = TW'(BURST_LEN - 1);
      end else if (stb.wr) begin
        nState = stb.ap ? BK_WRITE_AP : BK_WRITE;
        nTmr   = TW'(BURST_LEN - 1);
      end else if (stb.pre && (inBurst || state == BK_OPEN)) begin
        nState = BK_CLOSING;
        nTmr   = TW'(T_RP - 1);
      end else if (stb.bst && inBurst) begin
        nState = BK_OPEN;
      end else if (state != BK_IDLE && state != BK_OPEN) begin
        if (!expired) begin
          nTmr = tmr - 1'b1;
        end else begin
          case (state)
            BK_OPENING, BK_READ, BK_WREC: nState = BK_OPEN;
            BK_READ_AP, BK_WREC_AP: begin
              nState = BK_CLOSING;
              nTmr   = TW'(T_RP - 1);
            end
            BK_WRITE: begin
              nState = BK_WREC;
              nTmr   = TW'(T_WR - 1);
            end
            BK_WRITE_AP: begin
              nState = BK_WREC_AP;
              nTmr   = TW'(T_WR - 1);
            end
            default: nState = BK_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BK_IDLE;
      tmr   <= '0;
    end else begin
      state <= nState;
      tmr   <= nTmr;
    end
  end

endmodule

// File: rtl/sdram_track_dp.sv
module sdram_track_dp
  import sdram_legality_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_RC      = 8,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  parameter int TW        = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  bankStb_t [NUM_BANKS-1:0]  bStb,
  input  devStb_t                   dStb,
  output bank_e    [NUM_BANKS-1:0]  bankSt,
  output dev_e                      devSt
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_fsm #(
      .T_RCD    (T_RCD),
      .T_RP     (T_RP),
      .T_WR     (T_WR),
      .BURST_LEN(BURST_LEN),
      .TW       (TW)
    ) fsm_i (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (bStb[b]),
      .state(bankSt[b])
    );
  end

  logic [TW-1:0] devTmr;
  logic [TW-1:0] nDevTmr;
  dev_e          nDev;

  always_comb begin
    nDev    = devSt;
    nDevTmr = devTmr;
    if (!dStb.run) begin
      if (dStb.refSelf) nDev = DEV_SELF;
    end else if (dStb.mrs) begin
      nDev    = DEV_MODE;
      nDevTmr = TW'(T_MRD - 1);
    end else if (dStb.refAuto || dStb.selfExit) begin
      nDev    = DEV_REFRESH;
      nDevTmr = TW'(T_RC - 1);
    end else if (devSt == DEV_REFRESH || devSt == DEV_MODE) begin
      if (devTmr != '0) nDevTmr = devTmr - 1'b1;
      else              nDev    = DEV_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devSt  <= DEV_IDLE;
      devTmr <= '0;
    end else begin
      devSt  <= nDev;
      devTmr <= nDevTmr;
    end
  end

endmodule

// File: rtl/sdram_legality_ctrl.sv
module sdram_legality_ctrl
  import sdram_legality_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          csN,
  input  logic                          rasN,
  input  logic                          casN,
  input  logic                          weN,
  input  logic [$clog2(NUM_BANKS)-1:0]  ba,
  input  logic                          a10,
  input  logic                          cke,
  input  bank_e    [NUM_BANKS-1:0]      bankSt,
  input  dev_e                          devSt,
  output bankStb_t [NUM_BANKS-1:0]      bStb,
  output devStb_t                       dStb,
  output logic [3:0]                    cmdCode,
  output logic                          illegal
);

  localparam int BA_W = $clog2(NUM_BANKS);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] rwOk;
  logic [NUM_BANKS-1:0] preOk;
  logic [NUM_BANKS-1:0] apBusy;
  logic [NUM_BANKS-1:0] isIdle;
  logic                 allIdle;
  logic                 quiet;
  logic                 legalNow;
  logic                 fire;

  assign cmd     = decodeCmd(csN, rasN, casN, weN);
  assign quiet   = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  assign allIdle = (&isIdle) && (devSt == DEV_IDLE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rule
    assign isIdle[b] = (bankSt[b] == BK_IDLE);
    assign rwOk[b]   = (bankSt[b] == BK_OPEN) || (bankSt[b] == BK_READ) ||
                       (bankSt[b] == BK_WRITE) || (bankSt[b] == BK_WREC);
    assign preOk[b]  = (bankSt[b] == BK_IDLE) || (bankSt[b] == BK_OPEN) ||
                       (bankSt[b] == BK_READ) || (bankSt[b] == BK_WRITE) ||
                       (bankSt[b] == BK_CLOSING);
    assign apBusy[b] = (bankSt[b] == BK_READ_AP) || (bankSt[b] == BK_WRITE_AP) ||
                       (bankSt[b] == BK_WREC_AP);
  end

  always_comb begin
    legalNow = 1'b0;
    if (quiet) begin
      legalNow = 1'b1;
    end else if (!cke) begin
      legalNow = (cmd == CMD_REF) && allIdle;
    end else if (devSt == DEV_IDLE) begin
      case (cmd)
        CMD_MRS, CMD_REF: legalNow = allIdle;
        CMD_ACT:          legalNow = isIdle[ba];
        CMD_RD, CMD_WR:   legalNow = rwOk[ba];
        CMD_PRE:          legalNow = a10 ? (&preOk) : preOk[ba];
        CMD_BST:          legalNow = !apBusy[ba];
        default:          legalNow = 1'b0;
      endcase
    end
  end

  assign fire = legalNow && cke && (devSt == DEV_IDLE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stb
    logic sel;
    assign sel = (ba == BA_W'(b));
    assign bStb[b] = '{
      run: cke,
      act: fire && sel && (cmd == CMD_ACT),
      rd:  fire && sel && (cmd == CMD_RD),
      wr:  fire && sel && (cmd == CMD_WR),
      ap:  a10,
      pre: fire && (sel || a10) && (cmd == CMD_PRE),
      bst: fire && sel && (cmd == CMD_BST)
    };
  end

  assign dStb = '{
    run:      cke,
    mrs:      fire && (cmd == CMD_MRS),
    refAuto:  fire && (cmd == CMD_REF),
    refSelf:  legalNow && !cke && (cmd == CMD_REF),
    selfExit: cke && quiet && (devSt == DEV_SELF)
  };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdCode <= CMD_NOP;
      illegal <= 1'b0;
    end else begin
      cmdCode <= cmd;
      illegal <= !legalNow;
    end
  end

endmodule

// File: rtl/sdram_cmd_legality.sv
module sdram_cmd_legality
  import sdram_legality_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_RC      = 8,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          csN,
  input  logic                          rasN,
  input  logic                          casN,
  input  logic                          weN,
  input  logic [$clog2(NUM_BANKS)-1:0]  ba,
  input  logic                          a10,
  input  logic                          cke,
  output logic [3:0]                    cmdCode,
  output logic                          illegal,
  output logic [NUM_BANKS*4-1:0]        bankState,
  output logic [1:0]                    devState
);

  localparam int MAX_T = maxOf(maxOf(maxOf(T_RCD, T_RP), maxOf(T_WR, T_RC)),
                               maxOf(T_MRD, BURST_LEN));
  localparam int TW    = $clog2(MAX_T + 1);

  bankStb_t [NUM_BANKS-1:0] bStb;
  devStb_t                  dStb;
  bank_e    [NUM_BANKS-1:0] bankSt;
  dev_e                     devSt;

  sdram_legality_ctrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .csN    (csN),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN),
    .ba     (ba),
    .a10    (a10),
    .cke    (cke),
    .bankSt (bankSt),
    .devSt  (devSt),
    .bStb   (bStb),
    .dStb   (dStb),
    .cmdCode(cmdCode),
    .illegal(illegal)
  );

  sdram_track_dp #(
    .NUM_BANKS(NUM_BANKS),
    .T_RCD    (T_RCD),
    .T_RP     (T_RP),
    .T_WR     (T_WR),
    .T_RC     (T_RC),
    .T_MRD    (T_MRD),
    .BURST_LEN(BURST_LEN),
    .TW       (TW)
  ) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .bStb  (bStb),
    .dStb  (dStb),
    .bankSt(bankSt),
    .devSt (devSt)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flat
    assign bankState[b*4 +: 4] = bankSt[b];
  end
  assign devState = devSt;

endmodule

// File: rtl/sdram_cmd_legality_chk.sv
module sdram_cmd_legality_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          csN,
  input logic                          rasN,
  input logic                          casN,
  input logic                          weN,
  input logic [$clog2(NUM_BANKS)-1:0]  ba,
  input logic                          cke,
  input logic                          illegal,
  input logic [NUM_BANKS*4-1:0]        bankState
);

  logic [3:0] tgtSt;
  logic       isAct;
  logic       isRw;
  logic       isMrs;

  assign tgtSt = bankState[int'(ba)*4 +: 4];
  assign isAct = !csN && !rasN && casN && weN;
  assign isRw  = !csN && rasN && !casN;
  assign isMrs = !csN && !rasN && !casN && !weN;

  // R3
  act_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isAct && tgtSt != 4'd0) |=> illegal);

  // R4
  rw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isRw && tgtSt == 4'd0) |=> illegal);

  // R9
  mrs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isMrs && bankState != '0) |=> illegal);

  // R2
  desel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> !illegal);

  // R10
  cke_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bankState));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_path
    // R3
    opening_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bankState[b*4 +: 4] == 4'd1) |=>
        (bankState[b*4 +: 4] == 4'd1 || bankState[b*4 +: 4] == 4'd2));
    // R5
    read_ap_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bankState[b*4 +: 4] == 4'd5) |=>
        (bankState[b*4 +: 4] == 4'd5 || bankState[b*4 +: 4] == 4'd9));
  end

endmodule

bind sdram_cmd_legality sdram_cmd_legality_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .ba       (ba),
  .cke      (cke),
  .illegal  (illegal),
  .bankState(bankState)
);

// File: tb/sdram_cmd_legality_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_legality_tb_top;

  localparam int NB = 4;
  localparam int TRCD = 3, TRP = 3, TWR = 2, TRC = 8, TMRD = 2, BL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic cke = 1'b1;
  logic [3:0] cmdCode;
  logic illegal;
  logic [NB*4-1:0] bankState;
  logic [1:0] devState;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sdram_cmd_legality #(
    .NUM_BANKS(NB), .T_RCD(TRCD), .T_RP(TRP), .T_WR(TWR),
    .T_RC(TRC), .T_MRD(TMRD), .BURST_LEN(BL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .a10(a10), .cke(cke), .cmdCode(cmdCode), .illegal(illegal),
    .bankState(bankState), .devState(devState)
  );

  // ---------------- behavioural reference model ----------------
  int  mSt[NB];
  int  mTm[NB];
  int  mDev = 0;
  int  mDtm = 0;
  int  mCmd = 0;
  bit  mIll = 0;

  function automatic int pinCmd();
    if (csN) return 8;
    case ({rasN, casN, weN})
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 3;
      3'b011: return 4;
      3'b100: return 5;
      3'b101: return 6;
      3'b110: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic bit canPre(int s);
    return (s == 0 || s == 2 || s == 3 || s == 4 || s == 9);
  endfunction

  task automatic modelStep();
    int c;
    int b;
    bit ok;
    bit idleAll;
    c = pinCmd();
    b = int'(ba);
    idleAll = (mDev == 0);
    foreach (mSt[k]) if (mSt[k] != 0) idleAll = 0;
    ok = 0;
    if (c == 0 || c == 8) ok = 1;
    else if (!cke) ok = (c == 2) && idleAll;
    else if (mDev == 0) begin
      case (c)
        1, 2: ok = idleAll;
        4: ok = (mSt[b] == 0);
        5, 6: ok = (mSt[b] == 2 || mSt[b] == 3 || mSt[b] == 4 || mSt[b] == 7);
        3: begin
          if (a10) begin
            ok = 1;
            foreach (mSt[k]) if (!canPre(mSt[k])) ok = 0;
          end else ok = canPre(mSt[b]);
        end
        7: ok = !(mSt[b] == 5 || mSt[b] == 6 || mSt[b] == 8);
        default: ok = 0;
      endcase
    end
    mCmd = c;
    mIll = !ok;
    if (cke) begin
      for (int k = 0; k < NB; k++) begin
        bit go;
        go = ok && (mDev == 0);
        if (go && k == b && c == 4) begin mSt[k] = 1; mTm[k] = TRCD - 1; end
        else if (go && k == b && c == 6) begin mSt[k] = a10 ? 5 : 3; mTm[k] = BL - 1; end
        else if (go && k == b && c == 5) begin mSt[k] = a10 ? 6 : 4; mTm[k] = BL - 1; end
        else if (go && c == 3 && (a10 || k == b) && (mSt[k] >= 2 && mSt[k] <= 4)) begin
          mSt[k] = 9; mTm[k] = TRP - 1;
        end
        else if (go && k == b && c == 7 && (mSt[k] == 3 || mSt[k] == 4)) mSt[k] = 2;
        else if (mSt[k] != 0 && mSt[k] != 2) begin
          if (mTm[k] > 0) mTm[k]--;
          else begin
            case (mSt[k])
              1, 3, 7: mSt[k] = 2;
              5, 8: begin mSt[k] = 9; mTm[k] = TRP - 1; end
              4: begin mSt[k] = 7; mTm[k] = TWR - 1; end
              6: begin mSt[k] = 8; mTm[k] = TWR - 1; end
              default: mSt[k] = 0;
            endcase
          end
        end
      end
      if (ok && mDev == 0 && c == 1) begin mDev = 2; mDtm = TMRD - 1; end
      else if (ok && mDev == 0 && c == 2) begin mDev = 1; mDtm = TRC - 1; end
      else if (mDev == 3 && (c == 0 || c == 8)) begin mDev = 1; mDtm = TRC - 1; end
      else if (mDev == 1 || mDev == 2) begin
        if (mDtm > 0) mDtm--; else mDev = 0;
      end
    end else if (ok && c == 2) begin
      mDev = 3;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mSt[k]) begin mSt[k] = 0; mTm[k] = 0; end
      mDev = 0; mDtm = 0; mCmd = 0; mIll = 0;
    end else modelStep();
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bst(int k);
    return int'(bankState[k*4 +: 4]);
  endfunction

  bit compareOn = 0;
  always @(negedge clk) begin
    if (compareOn && rst_n) begin
      chk("R1 model cmdCode", int'(cmdCode), mCmd);
      chk("R11 model illegal", int'(illegal), int'(mIll));
      for (int k = 0; k < NB; k++) chk("R8 model bank state", bst(k), mSt[k]);
      chk("R9 model device state", int'(devState), mDev);
    end
  end

  // drive one command at a negedge, return at the next negedge
  task automatic issue(int c, int bank, bit ap, bit ck);
    if (c == 8) begin
      csN = 1'b1;
      {rasN, casN, weN} = 3'($urandom_range(0, 7));
    end else begin
      csN = 1'b0;
      case (c)
        1: {rasN, casN, weN} = 3'b000;
        2: {rasN, casN, weN} = 3'b001;
        3: {rasN, casN, weN} = 3'b010;
        4: {rasN, casN, weN} = 3'b011;
        5: {rasN, casN, weN} = 3'b100;
        6: {rasN, casN, weN} = 3'b101;
        7: {rasN, casN, weN} = 3'b110;
        default: {rasN, casN, weN} = 3'b111;
      endcase
    end
    ba = 2'(bank);
    a10 = ap;
    cke = ck;
    @(negedge clk);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compareOn = 1'b1;
    // R12 reset state
    chk("R12 bankState", int'(bankState), 0);
    chk("R12 devState", int'(devState), 0);
    chk("R12 illegal", int'(illegal), 0);
    chk("R12 cmdCode", int'(cmdCode), 0);

    nops(1);
    issue(1, 0, 0, 1);                       // mode load
    chk("R9 mode load legal", int'(illegal), 0);
    chk("R1 mode load code", int'(cmdCode), 1);
    chk("R9 mode access", int'(devState), 2);
    issue(4, 0, 0, 1);                       // activate during mode access
    chk("R9 activate in mode window", int'(illegal), 1);
    chk("R11 bank untouched", bst(0), 0);
    nops(1);
    chk("R9 mode window over", int'(devState), 0);

    issue(4, 0, 0, 1);
    chk("R3 activate idle", int'(illegal), 0);
    chk("R3 opening", bst(0), 1);
    issue(4, 0, 0, 1);
    chk("R3 activate opening bank", int'(illegal), 1);
    chk("R11 still opening", bst(0), 1);
    issue(6, 1, 0, 1);
    chk("R4 read idle bank", int'(illegal), 1);
    nops(1);
    chk("R3 open after T_RCD", bst(0), 2);
    issue(8, 3, 1, 1);
    chk("R2 deselect legal", int'(illegal), 0);
    chk("R1 deselect code", int'(cmdCode), 8);

    issue(6, 0, 0, 1);
    chk("R4 read open bank", bst(0), 3);
    nops(2);
    issue(6, 0, 0, 1);
    chk("R7 read restarts burst", int'(illegal), 0);
    nops(3);
    chk("R7 restarted burst still reading", bst(0), 3);
    issue(7, 0, 0, 1);
    chk("R7 burst stop opens", bst(0), 2);

    issue(5, 0, 0, 1);
    chk("R4 writing", bst(0), 4);
    nops(4);
    chk("R4 write recovery", bst(0), 7);
    issue(3, 0, 0, 1);
    chk("R6 precharge in recovery", int'(illegal), 1);
    chk("R11 recovery kept", bst(0), 7);
    nops(1);
    chk("R4 open after recovery", bst(0), 2);

    issue(4, 1, 0, 1);
    nops(3);
    chk("R3 bank1 open", bst(1), 2);
    issue(6, 1, 1, 1);
    chk("R5 read auto-precharge", bst(1), 5);
    issue(6, 1, 0, 1);
    chk("R5 read to AP bank", int'(illegal), 1);
    issue(6, 0, 0, 1);
    chk("R8 other bank read legal", int'(illegal), 0);
    chk("R8 AP bank unaffected", bst(1), 5);
    issue(3, 2, 1, 1);
    chk("R6 all-bank precharge blocked", int'(illegal), 1);
    nops(12);
    chk("R5 AP bank idle", bst(1), 0);
    chk("R4 read over", bst(0), 2);
    issue(3, 3, 1, 1);
    chk("R6 all-bank precharge", int'(illegal), 0);
    chk("R6 bank0 closing", bst(0), 9);
    chk("R6 idle bank stays", bst(1), 0);
    nops(3);
    chk("R6 idle after T_RP", bst(0), 0);

    issue(2, 0, 0, 1);
    chk("R9 refreshing", int'(devState), 1);
    issue(4, 0, 0, 1);
    chk("R9 activate while refreshing", int'(illegal), 1);
    nops(7);
    chk("R9 idle after T_RC", int'(devState), 0);

    issue(4, 2, 0, 1);
    nops(3);
    issue(6, 2, 0, 1);
    issue(0, 0, 0, 0);
    issue(0, 0, 0, 0);
    issue(0, 0, 0, 0);
    chk("R10 burst frozen", bst(2), 3);
    issue(4, 3, 0, 0);
    chk("R10 activate with CKE low", int'(illegal), 1);
    chk("R10 bank3 untouched", bst(3), 0);
    nops(4);
    chk("R10 burst resumes", bst(2), 2);
    issue(3, 2, 0, 1);
    nops(3);
    chk("R6 bank2 idle", bst(2), 0);

    issue(2, 0, 0, 0);
    chk("R10 self refresh entry", int'(devState), 3);
    chk("R10 entry legal", int'(illegal), 0);
    issue(0, 0, 0, 0);
    issue(6, 0, 0, 0);
    chk("R10 read in self refresh", int'(illegal), 1);
    issue(0, 0, 0, 1);
    chk("R10 exit to refreshing", int'(devState), 1);
    nops(8);
    chk("R10 idle after exit", int'(devState), 0);

    // random streams, model-compared every clock
    for (int i = 0; i < 3000; i++) begin
      int c;
      c = $urandom_range(0, 11);
      if (c > 8) c = (c == 9) ? 0 : ((c == 10) ? 4 : 6);
      issue(c, $urandom_range(0, 3), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 9) != 0));
    end
    nops(20);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule